// File: doc/BRIEF.md
# Set-Dueling Re-Reference Replacement Engine

This block makes the replacement decisions for a set-associative cache. Each line of each set holds a small re-reference prediction value (RRPV). A value near zero marks a line that is expected to be used again soon. The all-ones value marks a line that is expected to be used again late, or never. Tags and data live in another block. The cache controller tells this engine about lookups and fills, and the engine returns a victim way for each miss.

Requests come in on a valid/ready channel. Each request carries a set index, a hit flag and, for hits, the way that hit. A hit makes that line's value zero at once. A miss starts a victim search in that set. The search takes one cycle per aging step. In each step, if no line of the set is at the all-ones value, every line of the set goes up by one. Once a line is at all-ones, the lowest-numbered such way is returned with a one-cycle done pulse. While a miss is being served, `req_ready` is low. The controller must then hold `req_valid` and the request fields steady. A transfer happens only on a clock edge where valid and ready are both high.

Fills arrive on a plain strobe, which the engine accepts in any cycle. The value written into a filled line depends on the set. Some sets always use static insertion, which writes all-ones. Other sets always use bimodal insertion, which usually writes all-ones but now and then writes one less. A saturating selector counts the misses in these two groups of sets, and all remaining sets follow whichever insertion policy currently gives fewer misses.

Top module: `rrip_duel_repl`

## Requirements
- R1: An accepted hit request writes 0 into the RRPV of the given set and way on the next clock edge. A hit produces no done pulse and leaves the policy selector unchanged.
- R2: After reset, every RRPV is at its maximum (7 for 3-bit values), `req_ready` is 1 and `victim_done` is 0.
- R3: For an accepted miss, `victim_way` gives the lowest-numbered way of the set whose RRPV is at the maximum. `victim_done` is 1 exactly 2 + S clock edges after the accepting edge, where S is the maximum RRPV minus the largest RRPV in the set when the miss is accepted.
- R4: Each aging step adds exactly one to every RRPV of the searched set in one clock cycle. After a search that needed S steps, a line that started at value v holds v + S.
- R5: A fill under static insertion writes the maximum RRPV into the filled line.
- R6: A fill under bimodal insertion writes the maximum minus one when the low 5 bits of a free-running 16-bit LFSR are all zero (about 1 fill in 32), and writes the maximum otherwise.
- R7: Sets whose index modulo 8 is 0 always use static insertion. Sets whose index modulo 8 is 7 always use bimodal insertion. All other sets follow the selector.
- R8: The policy selector is a 10-bit saturating counter that resets to 511. An accepted miss in a static set adds one, and an accepted miss in a bimodal set subtracts one. The counter stops at 1023 and at 0 and never wraps. The other sets use bimodal insertion while bit 9 is 1.
- R9: `req_ready` is 0 from the cycle after a miss is accepted until `victim_done` goes high. No request is taken in that window.
- R10: `victim_done` is high for exactly one cycle for each miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can take a request |
| req_set | input | 6 | Set index of the request |
| req_hit | input | 1 | 1 = hit, 0 = miss |
| req_way | input | 2 | Way that hit (used on hits only) |
| fill_valid | input | 1 | Fill strobe |
| fill_set | input | 6 | Set of the filled line |
| fill_way | input | 2 | Way of the filled line |
| victim_way | output | 2 | Chosen victim, valid while `victim_done` is high |
| victim_done | output | 1 | One-cycle pulse that ends a miss |

## Verification
A hit or a fill lands on the clock edge that takes it. The end of a miss comes 2 + S edges after the accepting edge, where S is the number of aging steps. The bench counts falling edges from the accepting edge to `victim_done`, turns that count back into S, and compares it with the value expected from the RRPVs it has set up. RRPVs that are never visible at a port are read out this way. Each insertion value is found from the S of a later miss after the other ways have been cleared by hits. The selector's state is found by counting how many follower fills came in at maximum minus one. The bimodal odds are drawn from the LFSR. For that reason the bimodal checks ask for a count that is above zero but well under a quarter, rather than an exact count.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } srch_state_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/rrip_victim_find.sv
module rrip_victim_find #(
  parameter int WAYS   = 4,
  parameter int RRPV_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][RRPV_W-1:0] line_rrpv,
  output logic                        found,
  output logic [WAY_W-1:0]            victim
);
  logic [WAYS-1:0] at_max;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign at_max[w] = &line_rrpv[w];
  end

  always_comb begin
    found  = |at_max;
    victim = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (at_max[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rrip_insert_policy.sv
module rrip_insert_policy
  import rrip_pkg::*;
#(
  parameter int SETS        = 64,
  parameter int RRPV_W      = 3,
  parameter int DUEL_PERIOD = 8,
  parameter int PSEL_W      = 10,
  parameter int RARE_BITS   = 5,
  localparam int SET_W = $clog2(SETS),
  localparam int DP_W  = $clog2(DUEL_PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_evt,
  input  logic [SET_W-1:0]  miss_set,
  input  logic [SET_W-1:0]  fill_set,
  output logic [RRPV_W-1:0] ins_rrpv,
  output logic [PSEL_W-1:0] psel
);
  localparam logic [PSEL_W-1:0] PSEL_TOP  = '1;
  localparam logic [PSEL_W-1:0] PSEL_INIT = PSEL_TOP >> 1;
  localparam logic [RRPV_W-1:0] RMAX      = '1;

  logic [LFSR_W-1:0] lfsr;
  logic miss_static, miss_bimodal, fill_static, fill_bimodal, use_bimodal;

  assign miss_static  = (miss_set[DP_W-1:0] == '0);
  assign miss_bimodal = (miss_set[DP_W-1:0] == '1);
  assign fill_static  = (fill_set[DP_W-1:0] == '0);
  assign fill_bimodal = (fill_set[DP_W-1:0] == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= LFSR_SEED;
      psel <= PSEL_INIT;
    end else begin
      lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
      if (miss_evt && miss_static && psel != PSEL_TOP)
        psel <= psel + 1'b1;
      else if (miss_evt && miss_bimodal && psel != '0)
        psel <= psel - 1'b1;
    end
  end

  always_comb begin
    if (fill_static)       use_bimodal = 1'b0;
    else if (fill_bimodal) use_bimodal = 1'b1;
    else                   use_bimodal = psel[PSEL_W-1];
    ins_rrpv = (use_bimodal && lfsr[RARE_BITS-1:0] == '0) ? RMAX - 1'b1 : RMAX;
  end
endmodule

// File: rtl/rrip_duel_repl.sv
module rrip_duel_repl
  import rrip_pkg::*;
#(
  parameter int SETS        = 64,
  parameter int WAYS        = 4,
  parameter int RRPV_W      = 3,
  parameter int DUEL_PERIOD = 8,
  parameter int PSEL_W      = 10,
  parameter int RARE_BITS   = 5,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_done
);
  localparam logic [RRPV_W-1:0] RMAX = '1;

  logic [SETS-1:0][WAYS-1:0][RRPV_W-1:0] mem;
  srch_state_e       state;
  logic [SET_W-1:0]  cur_set;
  logic              accept, acc_miss, found, age_en;
  logic [WAY_W-1:0]  pick;
  logic [RRPV_W-1:0] ins_rrpv;
  logic [PSEL_W-1:0] psel;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign acc_miss  = accept && !req_hit;
  assign age_en    = (state == ST_SEARCH) && !found;

  rrip_victim_find #(.WAYS(WAYS), .RRPV_W(RRPV_W)) find_i (
    .line_rrpv (mem[cur_set]),
    .found     (found),
    .victim    (pick)
  );

  rrip_insert_policy #(
    .SETS(SETS), .RRPV_W(RRPV_W), .DUEL_PERIOD(DUEL_PERIOD),
    .PSEL_W(PSEL_W), .RARE_BITS(RARE_BITS)
  ) policy_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .miss_evt (acc_miss),
    .miss_set (req_set),
    .fill_set (fill_set),
    .ins_rrpv (ins_rrpv),
    .psel     (psel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_set     <= '0;
      victim_way  <= '0;
      victim_done <= 1'b0;
    end else begin
      victim_done <= 1'b0;
      case (state)
        ST_IDLE: if (acc_miss) begin
          state   <= ST_SEARCH;
          cur_set <= req_set;
        end
        ST_SEARCH: if (found) begin
          state       <= ST_IDLE;
          victim_way  <= pick;
          victim_done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w] <= RMAX;
    end else begin
      if (age_en)
        for (int w = 0; w < WAYS; w++)
          mem[cur_set][w] <= mem[cur_set][w] + 1'b1;
      if (accept && req_hit)
        mem[req_set][req_way] <= '0;
      if (fill_valid)
        mem[fill_set][fill_way] <= ins_rrpv;
    end
  end
endmodule

// File: rtl/rrip_duel_checker.sv
module rrip_duel_checker #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int RRPV_W = 3,
  parameter int PSEL_W = 10,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  req_valid,
  input logic                                  req_ready,
  input logic [SET_W-1:0]                      req_set,
  input logic                                  req_hit,
  input logic [WAY_W-1:0]                      req_way,
  input logic                                  fill_valid,
  input logic [SET_W-1:0]                      fill_set,
  input logic [WAY_W-1:0]                      fill_way,
  input logic                                  victim_done,
  input logic [SETS-1:0][WAYS-1:0][RRPV_W-1:0] mem,
  input logic [PSEL_W-1:0]                     psel
);
  localparam logic [PSEL_W-1:0] PTOP = '1;

  a_r1_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hit &&
     !(fill_valid && fill_set == req_set && fill_way == req_way))
    |=> mem[$past(req_set)][$past(req_way)] == '0);

  a_r8_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == PTOP) |=> (psel != '0));

  a_r8_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == '0) |=> (psel != PTOP));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> !$past(req_ready));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |=> !victim_done);
endmodule

bind rrip_duel_repl rrip_duel_checker #(
  .SETS(SETS), .WAYS(WAYS), .RRPV_W(RRPV_W), .PSEL_W(PSEL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_set(req_set), .req_hit(req_hit), .req_way(req_way),
  .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
  .victim_done(victim_done), .mem(mem), .psel(psel)
);

// File: tb/rrip_duel_repl_tb_top.sv
`timescale 1ns/1ps
module rrip_duel_repl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_hit = 1'b0, fill_valid = 1'b0;
  logic [5:0] req_set = '0, fill_set = '0;
  logic [1:0] req_way = '0, fill_way = '0;
  logic req_ready, victim_done;
  logic [1:0] victim_way;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rrip_duel_repl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_hit(req_hit), .req_way(req_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .victim_way(victim_way), .victim_done(victim_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_hit(input int s, input int w);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b1; req_set = 6'(s); req_way = 2'(w);
    @(negedge clk);
    req_valid = 1'b0; req_hit = 1'b0;
  endtask

  task automatic do_fill(input int s, input int w);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = 6'(s); fill_way = 2'(w);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // steps = aging steps derived from latency; busy_ok/pulse_ok cover R9/R10
  task automatic do_miss(input int s, output int steps, output int vic,
                         output bit busy_ok, output bit pulse_ok);
    int j;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_set = 6'(s);
    @(negedge clk);
    req_valid = 1'b0;
    j = 0;
    busy_ok = 1'b1;
    while (!victim_done && j < 40) begin
      j++;
      if (!victim_done && req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    j++;
    steps = j - 2;
    vic = victim_way;
    @(negedge clk);
    pulse_ok = !victim_done;
  endtask

  // fill way 0, clear ways 1..3, miss: steps 1 means way 0 got max-1
  task automatic trial(input int s, output bit low);
    int st, v; bit b, p;
    do_fill(s, 0);
    for (int w = 1; w < 4; w++) do_hit(s, w);
    do_miss(s, st, v, b, p);
    low = (st == 1);
    if (!(v == 0 && (st == 0 || st == 1)))
      chk(1'b0, "R3 trial victim/steps", v * 100 + st, 0);
  endtask

  task automatic count_lows(input int s, input int n, output int lows);
    bit l;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      trial(s, l);
      if (l) lows++;
    end
  endtask

  task automatic misses(input int s, input int n);
    int st, v; bit b, p;
    for (int i = 0; i < n; i++) do_miss(s, st, v, b, p);
  endtask

  task automatic t_reset;
    int st, v; bit b, p;
    chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
    chk(victim_done == 1'b0, "R2 done after reset", int'(victim_done), 0);
    do_miss(3, st, v, b, p);
    chk(st == 0 && v == 0, "R2 all lines at max after reset", st * 100 + v, 0);
    chk(b, "R9 ready low while searching", int'(b), 1);
    chk(p, "R10 done is one cycle", int'(p), 1);
  endtask

  task automatic t_aging;
    int st, v; bit b, p;
    for (int w = 0; w < 4; w++) do_hit(3, w);
    do_miss(3, st, v, b, p);
    chk(st == 7, "R1 hits cleared lines (aging steps)", st, 7);
    chk(v == 0, "R3 leftmost victim after aging", v, 0);
    do_miss(3, st, v, b, p);
    chk(st == 0, "R4 every line aged to max", st, 0);
    do_hit(3, 0);
    do_miss(3, st, v, b, p);
    chk(v == 1 && st == 0, "R3 tie picks lowest max way", v * 100 + st, 100);
    do_hit(3, 0); do_hit(3, 1); do_hit(3, 3);
    do_miss(3, st, v, b, p);
    chk(v == 2 && st == 0, "R3 single max line chosen", v * 100 + st, 200);
    for (int w = 0; w < 4; w++) do_hit(3, w);
    do_fill(3, 2);
    do_miss(3, st, v, b, p);
    chk(v == 2 && st == 0, "R5 follower static fill at max", v * 100 + st, 200);
  endtask

  task automatic t_policy;
    int lows;
    count_lows(5, 64, lows);
    chk(lows == 0, "R8 follower static at reset selector", lows, 0);
    count_lows(15, 256, lows);
    chk(lows > 0 && lows < 64, "R6 bimodal leader rare max-1", lows, 8);
    count_lows(16, 64, lows);
    chk(lows == 0, "R7 static leader always max", lows, 0);
    // selector now 511-256+64 = 319; 193 static misses reach 512
    misses(8, 193);
    count_lows(5, 256, lows);
    chk(lows > 0 && lows < 64, "R8 follower bimodal once msb set", lows, 8);
    misses(8, 1024);
    misses(7, 511);
    count_lows(5, 256, lows);
    chk(lows > 0 && lows < 64, "R8 selector saturated at top", lows, 8);
    misses(7, 1);
    count_lows(5, 64, lows);
    chk(lows == 0, "R8 follower back to static", lows, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_aging;
    t_policy;
    finish_run;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run;
  end
endmodule